// File: doc/BRIEF.md
# Super I/O Configuration Port

This block is the legacy I/O-space entry point to the configuration registers of a multi-function peripheral chip. The host reaches it through two adjacent byte ports. The lower address is an index port and the next address is a data port. After reset every configuration register is hidden. The host first writes a two-byte unlock key to the index port. From then on, each index write picks a configuration register, and data-port reads and writes reach that register. A single closing key byte written to the index port hides the space again.

Inside the block are the logical-device selector, two read-only identification bytes, a read-only copy of the base-address strap, and one activation bit per logical device. The block exports the selected logical device and the current register index. A downstream function, such as the watchdog in logical device 8, uses them to decode its own registers. Which of two base addresses the block answers on is fixed by a strap input, sampled while reset is held.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the port is locked (`cfg_open_o` = 0), `ldn_o` = 0, `idx_o` = 0, every `ld_active_o` bit is 0, and a data-port read returns 0xFF.
- R2: Two consecutive index-port writes of 0x87 while locked raise `cfg_open_o` in the cycle after the second write.
- R3: An index-port write of any value other than 0x87, directly after a first 0x87, cancels the partial key. The port stays locked until a fresh pair of 0x87 writes arrives.
- R4: While open, an index-port write of 0xAA locks the port and leaves `idx_o` unchanged. Later data-port reads return 0xFF.
- R5: While locked, data-port writes change nothing and data-port reads return 0xFF. Index-port writes do not change `idx_o`, and an index-port read returns 0xFF.
- R6: While open, an index-port write of any value other than 0xAA loads that value into `idx_o`, and an index-port read returns it. Register 0x07 is the read/write logical-device number, driven on `ldn_o`.
- R7: Register 0x20 reads as the DEV_ID parameter and register 0x21 reads as the DEV_REV parameter. Writes to either have no effect.
- R8: Register 0x26 reads with bit 6 equal to the strap sampled at reset and all other bits 0.
- R9: Register 0x30 bit 0 is the activation bit of the logical device selected in register 0x07. It is written from data bit 0, reads back in bit 0 with the other bits 0, and drives `ld_active_o[ldn]`. For a device number of NUM_LDN or more, writes are ignored and reads return 0.
- R10: The block decodes only the port pair at BASE_LO (strap 0) or BASE_HI (strap 1), the index at the base and the data at base+1. Accesses to any other address change no state and read 0xFF.
- R11: While open, a data-port read of any register other than 0x07, 0x20, 0x21, 0x26 and 0x30 returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; the strap is sampled while it is low |
| strap_i | input | 1 | Base select strap: 0 selects BASE_LO, 1 selects BASE_HI |
| addr_i | input | ADDR_W | I/O address of the access |
| wr_en_i | input | 1 | Byte write strobe |
| rd_en_i | input | 1 | Byte read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational, 0xFF when nothing decodes |
| cfg_open_o | output | 1 | Configuration space is unlocked |
| ldn_o | output | 8 | Selected logical device number |
| idx_o | output | 8 | Current register index |
| ld_active_o | output | NUM_LDN | Activation bit of each logical device |

## Verification
The bench builds two copies with NUM_LDN reduced to 10. Random device numbers therefore often land outside the implemented range, which exercises the ignored-write and zero-read path of the activation register. One copy has the strap low and the other has it high, and both share one host bus. Every access to one base pair is then a foreign-address access for the other copy. This tests the single-base decode in both directions, and it also tests the strap readback in both of its values.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  typedef enum logic [1:0] {KS_LOCKED, KS_HALF, KS_OPEN} key_st_e;

  localparam logic [7:0] KEY_ENTER = 8'h87;
  localparam logic [7:0] KEY_EXIT  = 8'hAA;

  localparam logic [7:0] REG_LDN   = 8'h07;
  localparam logic [7:0] REG_ID    = 8'h20;
  localparam logic [7:0] REG_REV   = 8'h21;
  localparam logic [7:0] REG_STRAP = 8'h26;
  localparam logic [7:0] REG_ACT   = 8'h30;

  localparam int STRAP_BIT = 6;
  localparam int ACT_BIT   = 0;
endpackage

// File: rtl/sio_addr_dec.sv
module sio_addr_dec #(
  parameter int          ADDR_W  = 16,
  parameter logic [15:0] BASE_LO = 16'h002E,
  parameter logic [15:0] BASE_HI = 16'h004E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strap_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output logic              strap_o,
  output logic              idx_wr_o,
  output logic              dat_wr_o,
  output logic              idx_rd_o,
  output logic              dat_rd_o
);
  localparam logic [ADDR_W-1:0] LO = ADDR_W'(BASE_LO);
  localparam logic [ADDR_W-1:0] HI = ADDR_W'(BASE_HI);

  logic              strap_q;
  logic [ADDR_W-1:0] base;
  logic              hit_idx, hit_dat;

  // static strap, captured while reset is asserted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strap_q <= strap_i;
    else         strap_q <= strap_q;
  end

  assign base     = strap_q ? HI : LO;
  assign hit_idx  = (addr_i == base);
  assign hit_dat  = (addr_i == base + ADDR_W'(1));
  assign idx_wr_o = wr_en_i & hit_idx;
  assign dat_wr_o = wr_en_i & hit_dat;
  assign idx_rd_o = rd_en_i & hit_idx;
  assign dat_rd_o = rd_en_i & hit_dat;
  assign strap_o  = strap_q;

  AST_STRAP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(strap_o)); // R8
endmodule

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
  import sio_cfg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_wr_i,
  input  logic [7:0] wdata_i,
  output logic       open_o,
  output logic       idx_ld_o
);
  key_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (idx_wr_i) begin
      unique case (st_q)
        KS_LOCKED: if (wdata_i == KEY_ENTER) st_d = KS_HALF;
        KS_HALF:   st_d = (wdata_i == KEY_ENTER) ? KS_OPEN : KS_LOCKED;
        KS_OPEN:   if (wdata_i == KEY_EXIT) st_d = KS_LOCKED;
        default:   st_d = KS_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= KS_LOCKED;
    else         st_q <= st_d;
  end

  assign open_o   = (st_q == KS_OPEN);
  assign idx_ld_o = idx_wr_i & open_o & (wdata_i != KEY_EXIT);

  AST_KEY_ENTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == KS_HALF && idx_wr_i && wdata_i == KEY_ENTER) |=> open_o); // R2
  AST_OPEN_NEEDS_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(st_q == KS_HALF && idx_wr_i)); // R2
  AST_KEY_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == KS_HALF && idx_wr_i && wdata_i != KEY_ENTER) |=> st_q == KS_LOCKED); // R3
  AST_KEY_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && idx_wr_i && wdata_i == KEY_EXIT) |=> !open_o); // R4
endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
#(
  parameter int         NUM_LDN = 16,
  parameter logic [7:0] DEV_ID  = 8'hC1,
  parameter logic [7:0] DEV_REV = 8'h2B
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               open_i,
  input  logic               strap_i,
  input  logic               idx_ld_i,
  input  logic               dat_wr_i,
  input  logic               idx_rd_i,
  input  logic               dat_rd_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  output logic [7:0]         idx_o,
  output logic [7:0]         ldn_o,
  output logic [NUM_LDN-1:0] act_o
);
  localparam int LDN_W = 8;

  logic [7:0]       idx_q;
  logic [LDN_W-1:0] ldn_q;
  logic             wr_ok, ldn_in_range, act_sel;
  logic [7:0]       dat_val;

  assign wr_ok        = dat_wr_i & open_i;
  assign ldn_in_range = (32'(ldn_q) < NUM_LDN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      ldn_q <= '0;
    end else begin
      if (idx_ld_i) idx_q <= wdata_i;
      if (wr_ok && idx_q == REG_LDN) ldn_q <= wdata_i;
    end
  end

  for (genvar g = 0; g < NUM_LDN; g++) begin : g_act
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) act_o[g] <= 1'b0;
      else if (wr_ok && idx_q == REG_ACT && 32'(ldn_q) == g) act_o[g] <= wdata_i[ACT_BIT];
    end
  end

  assign act_sel = ldn_in_range ? act_o[ldn_q] : 1'b0;

  always_comb begin
    unique case (idx_q)
      REG_LDN:   dat_val = ldn_q;
      REG_ID:    dat_val = DEV_ID;
      REG_REV:   dat_val = DEV_REV;
      REG_STRAP: dat_val = 8'(strap_i) << STRAP_BIT;
      REG_ACT:   dat_val = 8'(act_sel) << ACT_BIT;
      default:   dat_val = 8'hFF;
    endcase
  end

  always_comb begin
    rdata_o = 8'hFF;
    if (open_i && dat_rd_i)      rdata_o = dat_val;
    else if (open_i && idx_rd_i) rdata_o = idx_q;
  end

  assign idx_o = idx_q;
  assign ldn_o = ldn_q;

  AST_LOCKED_LDN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_i |=> $stable(ldn_o)); // R5
  AST_LOCKED_ACT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_i |=> $stable(act_o)); // R5
  AST_LOCKED_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_i |=> $stable(idx_o)); // R5
  AST_ID_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_i && dat_rd_i && idx_o == REG_ID) |-> rdata_o == DEV_ID); // R7
  AST_ACT_ONE_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(act_o ^ $past(act_o)) <= 1); // R9
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter logic [15:0] BASE_LO = 16'h002E,
  parameter logic [15:0] BASE_HI = 16'h004E,
  parameter int          NUM_LDN = 16,
  parameter logic [7:0]  DEV_ID  = 8'hC1,
  parameter logic [7:0]  DEV_REV = 8'h2B
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               strap_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  output logic               cfg_open_o,
  output logic [7:0]         ldn_o,
  output logic [7:0]         idx_o,
  output logic [NUM_LDN-1:0] ld_active_o
);
  logic strap, idx_wr, dat_wr, idx_rd, dat_rd, idx_ld;

  sio_addr_dec #(.ADDR_W(ADDR_W), .BASE_LO(BASE_LO), .BASE_HI(BASE_HI)) u_dec (
    .clk_i, .rst_ni, .strap_i, .addr_i, .wr_en_i, .rd_en_i,
    .strap_o(strap), .idx_wr_o(idx_wr), .dat_wr_o(dat_wr),
    .idx_rd_o(idx_rd), .dat_rd_o(dat_rd)
  );

  sio_key_fsm u_key (
    .clk_i, .rst_ni, .idx_wr_i(idx_wr), .wdata_i,
    .open_o(cfg_open_o), .idx_ld_o(idx_ld)
  );

  sio_cfg_regs #(.NUM_LDN(NUM_LDN), .DEV_ID(DEV_ID), .DEV_REV(DEV_REV)) u_regs (
    .clk_i, .rst_ni, .open_i(cfg_open_o), .strap_i(strap),
    .idx_ld_i(idx_ld), .dat_wr_i(dat_wr), .idx_rd_i(idx_rd), .dat_rd_i(dat_rd),
    .wdata_i, .rdata_o, .idx_o, .ldn_o, .act_o(ld_active_o)
  );

  logic [ADDR_W-1:0] sel_base;
  logic              foreign;
  assign sel_base = strap ? ADDR_W'(BASE_HI) : ADDR_W'(BASE_LO);
  assign foreign  = (addr_i != sel_base) && (addr_i != sel_base + ADDR_W'(1));

  AST_FOREIGN_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && foreign) |=> ($stable(cfg_open_o) && $stable(ldn_o) && $stable(idx_o)
                              && $stable(ld_active_o))); // R10
  AST_FOREIGN_READ_FF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && foreign) |-> rdata_o == 8'hFF); // R10
endmodule

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb;
  localparam int         N_LDN = 10;
  localparam logic [7:0] ID    = 8'hC1;
  localparam logic [7:0] REV   = 8'h2B;
  localparam logic [15:0] LO   = 16'h002E;
  localparam logic [15:0] HI   = 16'h004E;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wd = '0;
  logic [7:0] rdata_lo, rdata_hi, ldn_lo, ldn_hi, idx_lo, idx_hi;
  logic open_lo, open_hi;
  logic [N_LDN-1:0] act_lo, act_hi;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  sio_cfg_port #(.NUM_LDN(N_LDN), .DEV_ID(ID), .DEV_REV(REV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .strap_i(1'b0), .addr_i(addr), .wr_en_i(wr),
    .rd_en_i(rd), .wdata_i(wd), .rdata_o(rdata_lo), .cfg_open_o(open_lo),
    .ldn_o(ldn_lo), .idx_o(idx_lo), .ld_active_o(act_lo));

  sio_cfg_port #(.NUM_LDN(N_LDN), .DEV_ID(ID), .DEV_REV(REV)) u_dut_hi (
    .clk_i(clk), .rst_ni(rst_n), .strap_i(1'b1), .addr_i(addr), .wr_en_i(wr),
    .rd_en_i(rd), .wdata_i(wd), .rdata_o(rdata_hi), .cfg_open_o(open_hi),
    .ldn_o(ldn_hi), .idx_o(idx_hi), .ld_active_o(act_hi));

  // reference model of the strap-low copy: 0 locked, 1 half key, 2 open
  int m_mode = 0;
  logic [7:0] m_idx = '0, m_ldn = '0;
  logic [N_LDN-1:0] m_act = '0;

  function automatic logic [7:0] exp_dat();
    if (m_mode != 2) return 8'hFF;
    case (m_idx)
      8'h07: return m_ldn;
      8'h20: return ID;
      8'h21: return REV;
      8'h26: return 8'h00;
      8'h30: return (int'(m_ldn) < N_LDN) ? {7'b0, m_act[m_ldn]} : 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] exp_idx_rd();
    return (m_mode == 2) ? m_idx : 8'hFF;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] v);
    @(negedge clk);
    addr = a; wd = v; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    if (a == LO) begin
      case (m_mode)
        0: if (v == 8'h87) m_mode = 1;
        1: m_mode = (v == 8'h87) ? 2 : 0;
        default: if (v == 8'hAA) m_mode = 0; else m_idx = v;
      endcase
    end else if (a == LO + 16'd1 && m_mode == 2) begin
      if (m_idx == 8'h07) m_ldn = v;
      else if (m_idx == 8'h30 && int'(m_ldn) < N_LDN) m_act[m_ldn] = v[0];
    end
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] vlo, output logic [7:0] vhi);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1;
    vlo = rdata_lo; vhi = rdata_hi;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic chk_state(input string req);
    chk(req, {31'b0, open_lo}, {31'b0, m_mode == 2});
    chk(req, {24'b0, ldn_lo}, {24'b0, m_ldn});
    chk(req, {24'b0, idx_lo}, {24'b0, m_idx});
    chk(req, 32'(act_lo), 32'(m_act));
  endtask

  function automatic logic [7:0] pick_idx();
    case ($urandom % 9)
      0, 1: return 8'h87;
      2: return 8'hAA;
      3: return 8'h07;
      4: return 8'h20;
      5: return 8'h21;
      6: return 8'h26;
      7: return 8'h30;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] vl, vh;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_state("R1");
    bus_rd(LO + 16'd1, vl, vh);
    chk("R1", {24'b0, vl}, 32'hFF);

    // R5 locked writes/reads ignored
    bus_wr(LO + 16'd1, 8'h55);
    bus_wr(LO, 8'h07);
    chk("R5", {24'b0, idx_lo}, 32'h0);
    bus_rd(LO, vl, vh);
    chk("R5", {24'b0, vl}, 32'hFF);

    // R3 cancelled key
    bus_wr(LO, 8'h87);
    bus_wr(LO, 8'h12);
    bus_wr(LO, 8'h87);
    chk("R3", {31'b0, open_lo}, 32'h0);
    // R2 completing a fresh pair
    bus_wr(LO, 8'h87);
    chk("R2", {31'b0, open_lo}, 32'h1);

    // R6 LDN register, prior locked write had no effect
    bus_wr(LO, 8'h07);
    chk("R6", {24'b0, idx_lo}, 32'h07);
    bus_rd(LO, vl, vh);
    chk("R6", {24'b0, vl}, 32'h07);
    bus_rd(LO + 16'd1, vl, vh);
    chk("R5", {24'b0, vl}, 32'h00);
    bus_wr(LO + 16'd1, 8'h08);
    chk("R6", {24'b0, ldn_lo}, 32'h08);

    // R7 identification, read-only
    bus_wr(LO, 8'h20);
    bus_wr(LO + 16'd1, 8'h00);
    bus_rd(LO + 16'd1, vl, vh);
    chk("R7", {24'b0, vl}, {24'b0, ID});
    bus_wr(LO, 8'h21);
    bus_rd(LO + 16'd1, vl, vh);
    chk("R7", {24'b0, vl}, {24'b0, REV});

    // R8 strap low
    bus_wr(LO, 8'h26);
    bus_rd(LO + 16'd1, vl, vh);
    chk("R8", {24'b0, vl}, 32'h00);

    // R9 activation for LDN 8 and out of range LDN 12
    bus_wr(LO, 8'h30);
    bus_wr(LO + 16'd1, 8'hFF);
    chk("R9", {31'b0, act_lo[8]}, 32'h1);
    bus_rd(LO + 16'd1, vl, vh);
    chk("R9", {24'b0, vl}, 32'h01);
    bus_wr(LO, 8'h07);
    bus_wr(LO + 16'd1, 8'd12);
    bus_wr(LO, 8'h30);
    bus_wr(LO + 16'd1, 8'h01);
    chk("R9", 32'(act_lo), 32'(m_act));
    bus_rd(LO + 16'd1, vl, vh);
    chk("R9", {24'b0, vl}, 32'h00);

    // R11 unimplemented register
    bus_wr(LO, 8'hF5);
    bus_rd(LO + 16'd1, vl, vh);
    chk("R11", {24'b0, vl}, 32'hFF);

    // R4 exit key
    bus_wr(LO, 8'hAA);
    chk("R4", {31'b0, open_lo}, 32'h0);
    chk("R4", {24'b0, idx_lo}, 32'hF5);
    bus_rd(LO + 16'd1, vl, vh);
    chk("R4", {24'b0, vl}, 32'hFF);

    // random phase against the model
    for (int i = 0; i < 3000; i++) begin
      case ($urandom % 6)
        0, 1: bus_wr(LO, pick_idx());
        2: bus_wr(LO + 16'd1, ($urandom % 2) ? 8'($urandom % 16) : 8'($urandom));
        3: begin
          bus_rd(LO + 16'd1, vl, vh);
          chk((m_mode == 2 && m_idx == 8'h30) ? "R9" : "R11", {24'b0, vl}, {24'b0, exp_dat()});
        end
        4: begin
          bus_rd(LO, vl, vh);
          chk("R6", {24'b0, vl}, {24'b0, exp_idx_rd()});
        end
        default: begin
          bus_wr(($urandom % 2) ? HI : HI + 16'd1, pick_idx());
          bus_rd(16'h0060, vl, vh);
          chk("R10", {24'b0, vl}, 32'hFF);
        end
      endcase
      chk_state("R10");
    end

    // strap-high copy: lock it from any state, then test decode
    bus_wr(HI, 8'hAA);
    bus_wr(HI, 8'hAA);
    chk("R10", {31'b0, open_hi}, 32'h0);
    bus_wr(LO, 8'h87);
    bus_wr(LO, 8'h87);
    chk("R10", {31'b0, open_hi}, 32'h0);
    bus_wr(HI, 8'h87);
    bus_wr(HI, 8'h87);
    chk("R2", {31'b0, open_hi}, 32'h1);
    bus_wr(HI, 8'h26);
    bus_rd(HI + 16'd1, vl, vh);
    chk("R8", {24'b0, vh}, 32'h40);
    chk("R10", {24'b0, idx_hi}, 32'h26);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule